// File: doc/BRIEF.md
# Vertical Interval Timecode Line Serializer

The block builds the serial timecode waveform for one video line. A one-cycle strobe marks the leading edge of horizontal sync. If the line-enable input is high at that strobe, the block counts a fixed start delay in master clocks. The delay depends on the selected television standard. After the delay, the block sends 90 code bits, and each bit is held for eight master clocks.

The code is built from nine ten-bit groups. Each group starts with a synchronising pair of bits, 1 and then 0, followed by eight data bits sent least significant bit first. The first eight groups carry payload bytes read one at a time from an external byte memory. The ninth group carries a check byte computed inside the block.

The block has two outputs for a downstream keyer. The key-fill output is the code level. The key-enable output marks the span where code is present. The memory port is a fixed-latency read port with no back-pressure: a one-cycle read strobe with an address, and data returned on the following clock and held until the next strobe.

Top module: `vitc_line_serializer`

## Requirements
- R1: After reset, key_on, key_fill and mem_rd are all low.
- R2: When hsync_edge is sampled high together with line_en high, key_on rises at the clock edge exactly 150 master clocks later if std_pal is 0 (NTSC), or 167 clocks later if std_pal is 1 (PAL). std_pal is sampled with the strobe.
- R3: Each code bit on key_fill is held for exactly 8 master clocks. A line has 90 bits, so key_on stays high for exactly 720 clocks and then falls.
- R4: Each ten-bit group (bit positions 10g to 10g+9 for g from 0 to 8) starts with a 1 at position 10g and a 0 at position 10g+1. The next eight positions carry a byte, bit 0 first.
- R5: Groups 0 to 7 carry the memory bytes at addresses 0 to 7, in that order. There is exactly one read per group: a one-cycle mem_rd pulse with mem_addr, issued together with the group's first sync bit. The memory returns the byte on the next clock and holds it.
- R6: Group 8 carries a check byte for the generator polynomial x^8+1, sent bit 0 first. The check is taken over stream bits 0 to 81, so bit j of the byte is the XOR of every stream bit n in 0 to 81 with (81-n) mod 8 equal to j.
- R7: A strobe sampled with line_en low starts nothing: key_on and key_fill stay low and no read is issued.
- R8: A strobe that arrives during the delay or during the code aborts the current line, and key_on and key_fill are low after that edge. If line_en is high with that strobe, timing restarts from it as in R2.
- R9: key_fill is low whenever key_on is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, eight per code bit |
| rst_n | input | 1 | Active-low synchronous reset |
| std_pal | input | 1 | Standard select: 0 NTSC, 1 PAL; sampled with hsync_edge |
| line_en | input | 1 | Code enable for the line; sampled with hsync_edge |
| hsync_edge | input | 1 | One-cycle strobe at the leading edge of horizontal sync |
| mem_rd | output | 1 | One-cycle payload read strobe |
| mem_addr | output | 3 | Payload byte address |
| mem_rdata | input | 8 | Payload byte, valid the clock after mem_rd, held until the next read |
| key_fill | output | 1 | Registered serial code level |
| key_on | output | 1 | High while code bits are on key_fill |

## Verification
The assertions assume two things about the inputs. First, hsync_edge is a strobe that the environment only raises on purpose, because every high cycle is treated as a new line start or an abort. Second, the memory honours the stated one-clock latency and holds its data until the next read. The stimulus drives the strobe for a single clock at a time, and only at line starts or at deliberate abort points. Its memory model answers each read on the following edge and keeps the byte stable, so the groups never see data changing under them.

// File: rtl/vitc_pkg.sv
package vitc_pkg;
  typedef enum logic {STD_NTSC = 1'b0, STD_PAL = 1'b1} tv_std_e;

  localparam int unsigned DEF_NTSC_DLY = 150;
  localparam int unsigned DEF_PAL_DLY  = 167;
  localparam int unsigned DEF_BIT_CLKS = 8;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_SYNC_W   = 2;
  localparam int unsigned DEF_GROUPS   = 9;
endpackage

// File: rtl/vitc_start_timer.sv
module vitc_start_timer #(
  parameter int unsigned NTSC_DLY = vitc_pkg::DEF_NTSC_DLY,
  parameter int unsigned PAL_DLY  = vitc_pkg::DEF_PAL_DLY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_edge,
  input  logic line_en,
  input  logic std_pal,
  output logic fire
);
  localparam int unsigned MAX_DLY = (NTSC_DLY > PAL_DLY) ? NTSC_DLY : PAL_DLY;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

  vitc_pkg::tv_std_e std_sel;
  logic              armed;
  logic [CNT_W-1:0]  cnt;

  assign std_sel = vitc_pkg::tv_std_e'(std_pal);
  // a strobe always wins over the end of the delay
  assign fire = armed && (cnt == '0) && !hsync_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (hsync_edge) begin
      armed <= line_en;
      cnt   <= (std_sel == vitc_pkg::STD_PAL) ? CNT_W'(PAL_DLY - 1) : CNT_W'(NTSC_DLY - 1);
    end else if (fire) begin
      armed <= 1'b0;
    end else if (armed) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/vitc_bit_sequencer.sv
module vitc_bit_sequencer #(
  parameter int unsigned BIT_CLKS = vitc_pkg::DEF_BIT_CLKS,
  parameter int unsigned GRP_BITS = vitc_pkg::DEF_SYNC_W + vitc_pkg::DEF_DATA_W,
  parameter int unsigned GROUPS   = vitc_pkg::DEF_GROUPS,
  localparam int unsigned PH_W    = $clog2(BIT_CLKS),
  localparam int unsigned GW      = $clog2(GROUPS),
  localparam int unsigned PW      = $clog2(GRP_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          abort,
  output logic          active,
  output logic [PH_W-1:0] phase,
  output logic [PW-1:0] pos,
  output logic          load,
  output logic [GW-1:0] nxt_grp,
  output logic [PW-1:0] nxt_pos,
  output logic          end_line
);
  logic [GW-1:0] grp;
  logic          last_bit, step;

  assign last_bit = (grp == GW'(GROUPS - 1)) && (pos == PW'(GRP_BITS - 1));
  assign step     = active && (phase == PH_W'(BIT_CLKS - 1)) && !abort;
  assign end_line = step && last_bit;
  assign load     = fire || (step && !last_bit);

  always_comb begin
    if (fire) begin
      nxt_grp = '0;
      nxt_pos = '0;
    end else if (pos == PW'(GRP_BITS - 1)) begin
      nxt_grp = grp + 1'b1;
      nxt_pos = '0;
    end else begin
      nxt_grp = grp;
      nxt_pos = pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
      grp    <= '0;
      pos    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (fire) begin
      active <= 1'b1;
      phase  <= '0;
      grp    <= '0;
      pos    <= '0;
    end else if (active) begin
      if (phase == PH_W'(BIT_CLKS - 1)) begin
        phase <= '0;
        if (last_bit) begin
          active <= 1'b0;
        end else begin
          grp <= nxt_grp;
          pos <= nxt_pos;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vitc_crc.sv
module vitc_crc #(
  parameter int unsigned W = vitc_pkg::DEF_DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] base;
  assign base = clear ? '0 : crc;

  // x^8 + 1: rotate, folding the incoming bit into the low end
  always_ff @(posedge clk) begin
    if (!rst_n)  crc <= '0;
    else if (en) crc <= {base[W-2:0], base[W-1] ^ din};
  end
endmodule

// File: rtl/vitc_line_serializer.sv
module vitc_line_serializer #(
  parameter int unsigned NTSC_DLY = vitc_pkg::DEF_NTSC_DLY,
  parameter int unsigned PAL_DLY  = vitc_pkg::DEF_PAL_DLY,
  parameter int unsigned BIT_CLKS = vitc_pkg::DEF_BIT_CLKS,
  parameter int unsigned DATA_W   = vitc_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_W   = vitc_pkg::DEF_SYNC_W,
  parameter int unsigned GROUPS   = vitc_pkg::DEF_GROUPS,
  localparam int unsigned ADDR_W  = $clog2(GROUPS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_pal,
  input  logic              line_en,
  input  logic              hsync_edge,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              key_fill,
  output logic              key_on
);
  localparam int unsigned GRP_BITS = SYNC_W + DATA_W;
  localparam int unsigned GW       = $clog2(GROUPS);
  localparam int unsigned PW       = $clog2(GRP_BITS);
  localparam int unsigned PH_W     = $clog2(BIT_CLKS);
  localparam int unsigned DI_W     = $clog2(DATA_W);

  logic              fire, seq_active, load, end_line;
  logic [PH_W-1:0]   phase;
  logic [PW-1:0]     cur_pos, nxt_pos;
  logic [GW-1:0]     nxt_grp;
  logic [DATA_W-1:0] crc, src_byte, shreg;
  logic [DI_W-1:0]   data_idx;
  logic              nxt_bit, crc_group, in_check_data, first_data;

  vitc_start_timer #(.NTSC_DLY(NTSC_DLY), .PAL_DLY(PAL_DLY)) u_timer (
    .clk(clk), .rst_n(rst_n), .hsync_edge(hsync_edge), .line_en(line_en),
    .std_pal(std_pal), .fire(fire)
  );

  vitc_bit_sequencer #(.BIT_CLKS(BIT_CLKS), .GRP_BITS(GRP_BITS), .GROUPS(GROUPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .abort(hsync_edge),
    .active(seq_active), .phase(phase), .pos(cur_pos), .load(load),
    .nxt_grp(nxt_grp), .nxt_pos(nxt_pos), .end_line(end_line)
  );

  assign crc_group     = (nxt_grp == GW'(GROUPS - 1));
  assign in_check_data = crc_group && (nxt_pos >= PW'(SYNC_W));
  assign first_data    = (nxt_pos == PW'(SYNC_W));
  assign src_byte      = crc_group ? crc : mem_rdata;
  assign data_idx      = DI_W'(nxt_pos - PW'(SYNC_W));

  always_comb begin
    if (nxt_pos == PW'(0))      nxt_bit = 1'b1;
    else if (nxt_pos < PW'(SYNC_W)) nxt_bit = 1'b0;
    else if (first_data)        nxt_bit = src_byte[0];
    else                        nxt_bit = shreg[data_idx];
  end

  vitc_crc #(.W(DATA_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(fire), .en(load && !in_check_data),
    .din(nxt_bit), .crc(crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_on   <= 1'b0;
      key_fill <= 1'b0;
      shreg    <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_rd <= 1'b0;
      if (hsync_edge || end_line) begin
        key_on   <= 1'b0;
        key_fill <= 1'b0;
      end else if (load) begin
        key_on   <= 1'b1;
        key_fill <= nxt_bit;
        if (first_data) shreg <= src_byte;
        if ((nxt_pos == PW'(0)) && !crc_group) begin
          mem_rd   <= 1'b1;
          mem_addr <= nxt_grp[ADDR_W-1:0];
        end
      end
    end
  end

  assert_fill_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !key_on |-> !key_fill);

  assert_sync_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && cur_pos == PW'(0)) |-> key_fill);

  assert_sync_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && cur_pos == PW'(1)) |-> !key_fill);

  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && phase != '0) |-> ($stable(key_fill) && $stable(key_on)));

  assert_abort_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_edge |=> !key_on);

  assert_read_at_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (key_on && key_fill));

  assert_start_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !key_on);
endmodule

// File: tb/test_vitc_line_serializer.sv
`timescale 1ns/1ps
module test_vitc_line_serializer;
  logic       clk = 1'b0;
  logic       rst_n, std_pal, line_en, hsync_edge;
  logic       mem_rd, key_fill, key_on;
  logic [2:0] mem_addr;
  logic [7:0] mem_rdata;

  always #10 clk = ~clk;

  vitc_line_serializer i_vitc_line_serializer (
    .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .line_en(line_en),
    .hsync_edge(hsync_edge), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .key_fill(key_fill), .key_on(key_on)
  );

  logic [7:0]  mem_img [8];
  logic [89:0] exp_bits;
  int          rd_total = 0;
  logic [2:0]  rd_log [16];
  int          checks = 0, errors = 0;
  bit          done = 0;

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem_img[mem_addr];
      rd_log[rd_total % 16] <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_expected();
    logic [7:0] c;
    exp_bits = '0;
    for (int g = 0; g < 9; g++) begin
      exp_bits[10*g]   = 1'b1;
      exp_bits[10*g+1] = 1'b0;
      if (g < 8) for (int b = 0; b < 8; b++) exp_bits[10*g+2+b] = mem_img[g][b];
    end
    c = '0;
    for (int n = 0; n < 82; n++) c[(81 - n) % 8] ^= exp_bits[n];
    for (int j = 0; j < 8; j++) exp_bits[82+j] = c[j];
  endtask

  task automatic pulse_start(input bit pal, input bit en);
    @(negedge clk);
    std_pal = pal; line_en = en; hsync_edge = 1'b1;
  endtask

  // called at the negedge right after the strobe edge (j = 0)
  task automatic watch_line(input bit pal, input bit en, input int abort_at,
                            input bit ab_pal, input bit ab_en);
    int d;
    d = pal ? 167 : 150;
    for (int j = 0; j < d + 730; j++) begin
      bit    exp_on, exp_f;
      string tag;
      int    n;
      exp_on = en && (j >= d) && (j < d + 720);
      n      = exp_on ? (j - d) / 8 : 0;
      exp_f  = exp_on ? exp_bits[n] : 1'b0;
      if (!en)                        tag = "R7";
      else if (j == d)                tag = "R2";
      else if (!exp_on)               tag = (j > d) ? "R3" : "R2";
      else                            tag = "R3";
      chk(key_on == exp_on, tag, $sformatf("key_on j=%0d", j), int'(key_on), int'(exp_on));
      if (!exp_on)                    tag = en ? "R9" : "R7";
      else if (n >= 82)               tag = "R6";
      else if ((n % 10) < 2)          tag = "R4";
      else                            tag = "R5";
      chk(key_fill == exp_f, tag, $sformatf("key_fill j=%0d", j), int'(key_fill), int'(exp_f));
      if (j == abort_at) begin
        std_pal = ab_pal; line_en = ab_en; hsync_edge = 1'b1;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_line(input bit pal, input bit en);
    int base;
    build_expected();
    pulse_start(pal, en);
    base = rd_total;
    @(negedge clk); hsync_edge = 1'b0;
    watch_line(pal, en, -1, 1'b0, 1'b0);
    if (en) begin
      chk(rd_total - base == 8, "R5", "read count", rd_total - base, 8);
      for (int a = 0; a < 8; a++)
        chk(rd_log[(base + a) % 16] == 3'(a), "R5", "read order", int'(rd_log[(base + a) % 16]), a);
    end else begin
      chk(rd_total == base, "R7", "reads on disabled line", rd_total - base, 0);
    end
  endtask

  task automatic run_abort(input bit pal, input int at, input bit ab_pal, input bit ab_en);
    build_expected();
    pulse_start(pal, 1'b1);
    @(negedge clk); hsync_edge = 1'b0;
    watch_line(pal, 1'b1, at, ab_pal, ab_en);
    @(negedge clk); hsync_edge = 1'b0;
    chk(key_on == 1'b0, "R8", "key_on after abort", int'(key_on), 0);
    chk(key_fill == 1'b0, "R8", "key_fill after abort", int'(key_fill), 0);
    // restarted (or cancelled) line timed from the abort strobe
    watch_line(ab_pal, ab_en, -1, 1'b0, 1'b0);
  endtask

  task automatic fill(input int kind, input int arg);
    for (int g = 0; g < 8; g++) begin
      case (kind)
        0: mem_img[g] = 8'h00;
        1: mem_img[g] = 8'hFF;
        2: mem_img[g] = 8'(g * 8'h11 + 3);
        3: mem_img[g] = (g % 2 == 0) ? 8'hA5 : 8'h5A;
        4: mem_img[g] = (g == arg / 8) ? 8'(1 << (arg % 8)) : 8'h00;
        default: mem_img[g] = (g == arg) ? 8'(1 << g) : 8'h00;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; std_pal = 1'b0; line_en = 1'b0; hsync_edge = 1'b0;
    mem_rdata = 8'h00;
    fill(0, 0);
    repeat (3) @(negedge clk);
    chk(key_on == 1'b0, "R1", "key_on in reset", int'(key_on), 0);
    chk(key_fill == 1'b0, "R1", "key_fill in reset", int'(key_fill), 0);
    chk(mem_rd == 1'b0, "R1", "mem_rd in reset", int'(mem_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(key_on == 1'b0, "R1", "key_on after reset", int'(key_on), 0);

    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++) begin
        fill(k, 0);
        run_line(p[0], 1'b1);
      end
    for (int b = 0; b < 64; b++) begin
      fill(4, b);
      run_line(1'b0, 1'b1);
    end
    for (int g = 0; g < 8; g++) begin
      fill(5, g);
      run_line(1'b1, 1'b1);
    end
    fill(2, 0);
    run_line(1'b0, 1'b0);
    run_line(1'b1, 1'b0);
    run_abort(1'b0, 150 + 200, 1'b1, 1'b1);
    run_abort(1'b1, 50, 1'b0, 1'b1);
    run_abort(1'b0, 150 + 400, 1'b0, 1'b0);
    fill(3, 0);
    run_line(1'b1, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule